// File: doc/BRIEF.md
# Sparse Column Extended-Addition Unit

This block is one lane of a sparse multifrontal factorization datapath. It builds one column of a frontal matrix before that column is scaled. The frontal column and the matching columns of every child update matrix arrive as streams of (row index, value) pairs. Within each column the row indices rise strictly, and only lower-triangle entries are present. A child entry is added into the frontal entry that has the same row index. Frontal rows that no child touches come out unchanged. A child row that has no frontal counterpart is reported and dropped, because the fill pattern was fixed before numerical work starts.

The caller pulses `start` together with the number of child columns for the node. The unit then takes the frontal column into a local store. Next it takes exactly that many child columns, each ended by its own `last` flag, and adds each accepted child entry in a single cycle using a parallel row-index compare. Finally it streams the merged column out in ascending row order and pulses `done`, which starts the scaling stage. With a child count of zero the frontal column bypasses the store and leaves through the output register, one cycle behind each accepted entry. Values are signed fixed-point, and every add saturates.

The states are IDLE, PASS, LOAD, MERGE, DRAIN, FLUSH and DONE, with these transitions:

- IDLE→PASS on `start` with a zero child count; IDLE→LOAD on `start` with a nonzero count.
- PASS→FLUSH when the last frontal entry is accepted; LOAD→MERGE on the same event.
- MERGE→DRAIN when the last entry of the final child column is accepted.
- DRAIN→FLUSH once the final stored entry is loaded into the output register.
- FLUSH→DONE when that output is taken; DONE→IDLE after one cycle.

Top module: `col_merge_unit`

## Requirements
- R1: After reset, `out_valid`, `done`, `busy`, `miss_err`, `ovf`, `fr_ready` and `ch_ready` are all 0.
- R2: With a child count of 0, each frontal entry accepted at a clock edge appears on the output after that edge with identical row, value and last flag.
- R3: Every child entry whose row index equals a frontal row index is added into that frontal value. Entries from several children that hit the same row accumulate.
- R4: Frontal rows that no child entry matches are emitted with their value unchanged.
- R5: A child entry whose row index is absent from the frontal column sets the sticky `miss_err` flag. No row is inserted, so the output has exactly as many entries as the frontal column. `start` in IDLE clears the flag.
- R6: Sums saturate to the largest or smallest signed DW-bit value (32767 and -32768 at DW=16) and set the sticky `ovf` flag. `start` in IDLE clears the flag.
- R7: The merged column is emitted in the frontal order (strictly ascending rows). `out_last` is 1 only on its final entry.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_row`, `out_val` and `out_last` hold steady.
- R9: `fr_ready` and `ch_ready` are never both 1. `ch_ready` is 0 while the frontal column loads. `done` is a single-cycle pulse in the cycle after the final output handshake.
- R10: Exactly `n_child` child columns (counted by `ch_last`) are consumed, after which `ch_ready` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a column (taken in IDLE) |
| n_child | input | CW | Number of child update columns |
| busy | output | 1 | Unit is not idle |
| fr_valid | input | 1 | Frontal entry valid |
| fr_ready | output | 1 | Frontal entry accepted |
| fr_row | input | RW | Frontal row index |
| fr_val | input | DW | Frontal value (signed) |
| fr_last | input | 1 | Final frontal entry |
| ch_valid | input | 1 | Child entry valid |
| ch_ready | output | 1 | Child entry accepted |
| ch_row | input | RW | Child row index |
| ch_val | input | DW | Child value (signed) |
| ch_last | input | 1 | Final entry of a child column |
| out_valid | output | 1 | Merged entry valid |
| out_ready | input | 1 | Downstream accepts entry |
| out_row | output | RW | Merged row index |
| out_val | output | DW | Merged value (signed) |
| out_last | output | 1 | Final merged entry |
| done | output | 1 | Merge complete pulse |
| miss_err | output | 1 | Sticky unmatched-child-row flag |
| ovf | output | 1 | Sticky saturation flag |

## Verification
The bound checker watches several properties on every cycle:

- the two input phases never overlap;
- the output holds while stalled;
- `done` lasts one cycle;
- the error and saturation flags stay set until a new start;
- emitted rows rise within a column.

The arithmetic can only be shown by the directed scenarios: matched sums, accumulation across children, untouched rows, dropped unmatched rows, saturation at both limits and exact one-cycle bypass latency. The same holds for counting child columns.

// File: rtl/col_merge_pkg.sv
package col_merge_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_PASS,
        S_LOAD,
        S_MERGE,
        S_DRAIN,
        S_FLUSH,
        S_DONE
    } merge_state_t;
endpackage

// File: rtl/sat_adder.sv
module sat_adder #(
    parameter int DW = 16
) (
    input  logic signed [DW-1:0] a,
    input  logic signed [DW-1:0] b,
    output logic signed [DW-1:0] sum,
    output logic                 clipped
);
    localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

    logic signed [DW:0] wide;

    always_comb begin
        wide    = {a[DW-1], a} + {b[DW-1], b};
        clipped = (wide[DW] != wide[DW-1]);
        if (!clipped)
            sum = wide[DW-1:0];
        else if (wide[DW])
            sum = MINV;
        else
            sum = MAXV;
    end
endmodule

// File: rtl/col_store.sv
module col_store #(
    parameter int DEPTH = 16,
    parameter int RW    = 8,
    parameter int DW    = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     wr_en,
    input  logic [RW-1:0]            wr_row,
    input  logic signed [DW-1:0]     wr_val,
    input  logic                     add_en,
    input  logic [RW-1:0]            add_row,
    input  logic signed [DW-1:0]     add_val,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [RW-1:0]            rd_row,
    output logic signed [DW-1:0]     rd_val,
    output logic                     hit,
    output logic                     add_ovf,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int IW   = $clog2(DEPTH);
    localparam int CNTW = $clog2(DEPTH+1);

    logic [RW-1:0]        row_q [DEPTH];
    logic signed [DW-1:0] val_q [DEPTH];
    logic [CNTW-1:0]      count_q;
    logic [DEPTH-1:0]     eq;
    logic signed [DW-1:0] old_val;
    logic signed [DW-1:0] new_val;
    logic                 clip;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign eq[i] = (CNTW'(i) < count_q) && (row_q[i] == add_row);
    end

    always_comb begin
        old_val = '0;
        for (int i = 0; i < DEPTH; i++)
            if (eq[i]) old_val = old_val | val_q[i];
    end

    sat_adder #(.DW(DW)) u_add (
        .a(old_val), .b(add_val), .sum(new_val), .clipped(clip)
    );

    assign hit     = |eq;
    assign add_ovf = hit & clip;
    assign count   = count_q;
    assign rd_row  = row_q[rd_idx];
    assign rd_val  = val_q[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr) begin
            count_q <= '0;
        end else if (wr_en && count_q < CNTW'(DEPTH)) begin
            count_q <= count_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !clr && count_q < CNTW'(DEPTH)) begin
            row_q[count_q[IW-1:0]] <= wr_row;
            val_q[count_q[IW-1:0]] <= wr_val;
        end
        if (add_en) begin
            for (int i = 0; i < DEPTH; i++)
                if (eq[i]) val_q[i] <= new_val;
        end
    end
endmodule

// File: rtl/col_merge_unit.sv
module col_merge_unit
    import col_merge_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int RW    = 8,
    parameter int DW    = 16,
    parameter int CW    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [CW-1:0]        n_child,
    output logic                 busy,
    input  logic                 fr_valid,
    output logic                 fr_ready,
    input  logic [RW-1:0]        fr_row,
    input  logic signed [DW-1:0] fr_val,
    input  logic                 fr_last,
    input  logic                 ch_valid,
    output logic                 ch_ready,
    input  logic [RW-1:0]        ch_row,
    input  logic signed [DW-1:0] ch_val,
    input  logic                 ch_last,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [RW-1:0]        out_row,
    output logic signed [DW-1:0] out_val,
    output logic                 out_last,
    output logic                 done,
    output logic                 miss_err,
    output logic                 ovf
);
    localparam int IW   = $clog2(DEPTH);
    localparam int CNTW = $clog2(DEPTH+1);

    merge_state_t state_q, state_d;

    logic [CW-1:0]        kids_q;
    logic [IW-1:0]        rd_idx_q;
    logic                 ov_q, ol_q, miss_q, ovf_q;
    logic [RW-1:0]        orow_q;
    logic signed [DW-1:0] oval_q;

    logic                 out_free, fr_fire, ch_fire, drain_ld, drain_last;
    logic                 st_hit, st_ovf;
    logic [RW-1:0]        st_row;
    logic signed [DW-1:0] st_val;
    logic [CNTW-1:0]      st_cnt;

    assign out_free   = !ov_q || out_ready;
    assign fr_ready   = (state_q == S_LOAD) || (state_q == S_PASS && out_free);
    assign ch_ready   = (state_q == S_MERGE);
    assign fr_fire    = fr_valid && fr_ready;
    assign ch_fire    = ch_valid && ch_ready;
    assign drain_ld   = (state_q == S_DRAIN) && out_free;
    assign drain_last = (CNTW'(rd_idx_q) + 1'b1) == st_cnt;

    col_store #(.DEPTH(DEPTH), .RW(RW), .DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state_q == S_IDLE && start),
        .wr_en   (state_q == S_LOAD && fr_fire),
        .wr_row  (fr_row),
        .wr_val  (fr_val),
        .add_en  (ch_fire),
        .add_row (ch_row),
        .add_val (ch_val),
        .rd_idx  (rd_idx_q),
        .rd_row  (st_row),
        .rd_val  (st_val),
        .hit     (st_hit),
        .add_ovf (st_ovf),
        .count   (st_cnt)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = (n_child == '0) ? S_PASS : S_LOAD;
            S_PASS:  if (fr_fire && fr_last) state_d = S_FLUSH;
            S_LOAD:  if (fr_fire && fr_last) state_d = S_MERGE;
            S_MERGE: if (ch_fire && ch_last && kids_q == CW'(1)) state_d = S_DRAIN;
            S_DRAIN: if (drain_ld && drain_last) state_d = S_FLUSH;
            S_FLUSH: if (ov_q && out_ready && ol_q) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kids_q   <= '0;
            rd_idx_q <= '0;
            miss_q   <= 1'b0;
            ovf_q    <= 1'b0;
            ov_q     <= 1'b0;
            ol_q     <= 1'b0;
            orow_q   <= '0;
            oval_q   <= '0;
        end else begin
            if (state_q == S_IDLE && start) begin
                kids_q   <= n_child;
                rd_idx_q <= '0;
                miss_q   <= 1'b0;
                ovf_q    <= 1'b0;
            end
            if (ch_fire) begin
                if (!st_hit) miss_q <= 1'b1;
                if (st_ovf)  ovf_q  <= 1'b1;
                if (ch_last) kids_q <= kids_q - 1'b1;
            end
            if (state_q == S_PASS && fr_fire) begin
                ov_q   <= 1'b1;
                orow_q <= fr_row;
                oval_q <= fr_val;
                ol_q   <= fr_last;
            end else if (drain_ld) begin
                ov_q     <= 1'b1;
                orow_q   <= st_row;
                oval_q   <= st_val;
                ol_q     <= drain_last;
                rd_idx_q <= rd_idx_q + 1'b1;
            end else if (ov_q && out_ready) begin
                ov_q <= 1'b0;
                ol_q <= 1'b0;
            end
        end
    end

    assign busy      = (state_q != S_IDLE);
    assign done      = (state_q == S_DONE);
    assign out_valid = ov_q;
    assign out_row   = orow_q;
    assign out_val   = oval_q;
    assign out_last  = ol_q;
    assign miss_err  = miss_q;
    assign ovf       = ovf_q;
endmodule

// File: rtl/col_merge_chk.sv
module col_merge_chk #(
    parameter int RW = 8,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          fr_ready,
    input logic          ch_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [RW-1:0] out_row,
    input logic [DW-1:0] out_val,
    input logic          out_last,
    input logic          done,
    input logic          miss_err,
    input logic          ovf
);
    logic          have_prev;
    logic [RW-1:0] prev_row;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_prev <= 1'b0;
            prev_row  <= '0;
        end else if (out_valid && out_ready) begin
            have_prev <= !out_last;
            prev_row  <= out_row;
        end
    end

    // R9
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fr_ready && ch_ready));

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_row)
                                       && $stable(out_val) && $stable(out_last)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(start && !busy)) |=> ovf);

    // R5
    miss_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_err && !(start && !busy)) |=> miss_err);

    // R7
    row_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && have_prev) |-> (out_row > prev_row));
endmodule

bind col_merge_unit col_merge_chk #(.RW(RW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .fr_ready(fr_ready), .ch_ready(ch_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_row(out_row), .out_val(out_val),
    .out_last(out_last), .done(done), .miss_err(miss_err), .ovf(ovf)
);

// File: tb/col_merge_unit_tb.sv
module col_merge_unit_tb;
    localparam int RW = 8;
    localparam int DW = 16;
    localparam int CW = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0;
    logic [CW-1:0] n_child = '0;
    logic busy;
    logic fr_valid = 1'b0, fr_last = 1'b0, fr_ready;
    logic [RW-1:0] fr_row = '0;
    logic signed [DW-1:0] fr_val = '0;
    logic ch_valid = 1'b0, ch_last = 1'b0, ch_ready;
    logic [RW-1:0] ch_row = '0;
    logic signed [DW-1:0] ch_val = '0;
    logic out_valid, out_last, done, miss_err, ovf;
    logic out_ready = 1'b0;
    logic [RW-1:0] out_row;
    logic signed [DW-1:0] out_val;

    int checks = 0, errors = 0;
    int got_n;
    int got_row [16];
    int got_val [16];
    int got_last [16];
    int exp_row [16];
    int exp_val [16];
    bit finished = 1'b0;

    always #4 clk = ~clk;

    col_merge_unit #(.DEPTH(16), .RW(RW), .DW(DW), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .n_child(n_child), .busy(busy),
        .fr_valid(fr_valid), .fr_ready(fr_ready), .fr_row(fr_row), .fr_val(fr_val),
        .fr_last(fr_last), .ch_valid(ch_valid), .ch_ready(ch_ready), .ch_row(ch_row),
        .ch_val(ch_val), .ch_last(ch_last), .out_valid(out_valid), .out_ready(out_ready),
        .out_row(out_row), .out_val(out_val), .out_last(out_last), .done(done),
        .miss_err(miss_err), .ovf(ovf)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic do_start(input int n);
        @(negedge clk);
        start = 1'b1; n_child = CW'(n);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic push_fr(input int r, input int v, input bit l);
        fr_valid = 1'b1; fr_row = RW'(r); fr_val = DW'(v); fr_last = l;
        while (!fr_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        fr_valid = 1'b0;
    endtask

    task automatic push_ch(input int r, input int v, input bit l);
        ch_valid = 1'b1; ch_row = RW'(r); ch_val = DW'(v); ch_last = l;
        while (!ch_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        ch_valid = 1'b0;
    endtask

    // called at a negedge; drains one column and checks the done pulse (R9)
    task automatic collect(input string tag);
        got_n = 0;
        out_ready = 1'b1;
        for (int k = 0; k < 200; k++) begin
            if (out_valid) begin
                got_row[got_n]  = int'(out_row);
                got_val[got_n]  = int'(out_val);
                got_last[got_n] = int'(out_last);
                got_n++;
                if (out_last || got_n == 16) break;
            end
            @(negedge clk);
        end
        @(posedge clk);
        @(negedge clk);
        check(done == 1'b1, {tag, " R9 done pulse"}, int'(done), 1);
        @(negedge clk);
        check(done == 1'b0, {tag, " R9 done single"}, int'(done), 0);
    endtask

    task automatic compare(input int n, input string tag);
        check(got_n == n, {tag, " R5 entry count"}, got_n, n);
        for (int i = 0; i < n && i < got_n; i++) begin
            check(got_row[i] == exp_row[i], {tag, " R7 row"}, got_row[i], exp_row[i]);
            check(got_val[i] == exp_val[i], {tag, " R3 value"}, got_val[i], exp_val[i]);
            check(got_last[i] == int'(i == n-1), {tag, " R7 last"}, got_last[i], int'(i == n-1));
        end
    endtask

    task automatic t_reset();
        check(!out_valid && !done && !busy, "R1 outputs idle", int'(out_valid), 0);
        check(!miss_err && !ovf, "R1 flags clear", int'(miss_err | ovf), 0);
        check(!fr_ready && !ch_ready, "R1 readies low", int'(fr_ready | ch_ready), 0);
    endtask

    task automatic t_pass();
        int rows [3] = '{2, 5, 9};
        int vals [3] = '{100, -7, 33};
        do_start(0);
        out_ready = 1'b1;
        for (int i = 0; i < 3; i++) begin
            fr_valid = 1'b1; fr_row = RW'(rows[i]); fr_val = DW'(vals[i]); fr_last = (i == 2);
            @(posedge clk);
            @(negedge clk);
            fr_valid = 1'b0;
            check(out_valid && int'(out_row) == rows[i], "R2 pass row", int'(out_row), rows[i]);
            check(int'(out_val) == vals[i], "R2 pass value", int'(out_val), vals[i]);
            check(out_last == (i == 2), "R2 pass last", int'(out_last), int'(i == 2));
        end
        @(posedge clk);
        @(negedge clk);
        check(done == 1'b1, "R9 pass done", int'(done), 1);
        @(negedge clk);
    endtask

    task automatic t_merge();
        out_ready = 1'b0;
        do_start(2);
        check(ch_ready == 1'b0, "R9 no child during load", int'(ch_ready), 0);
        push_fr(3, 10, 0); push_fr(4, 20, 0); push_fr(6, 30, 0);
        push_fr(8, 40, 0); push_fr(11, 50, 1);
        push_ch(4, 5, 0);  push_ch(8, -15, 1);
        push_ch(4, 1, 0);  push_ch(11, 7, 1);
        check(ch_ready == 1'b0, "R10 child intake closed", int'(ch_ready), 0);
        exp_row = '{3, 4, 6, 8, 11, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
        exp_val = '{10, 26, 30, 25, 57, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
        collect("merge");
        compare(5, "merge R4");
        check(!miss_err && !ovf, "R3 no flags", int'(miss_err | ovf), 0);
    endtask

    task automatic t_miss();
        do_start(1);
        push_fr(1, 1, 0); push_fr(5, 2, 1);
        push_ch(3, 9, 0); push_ch(5, 4, 1);
        check(miss_err == 1'b1, "R5 miss flagged", int'(miss_err), 1);
        exp_row[0] = 1; exp_val[0] = 1;
        exp_row[1] = 5; exp_val[1] = 6;
        collect("miss");
        compare(2, "miss R5");
        check(miss_err == 1'b1, "R5 miss sticky", int'(miss_err), 1);
    endtask

    task automatic t_sat();
        do_start(1);
        check(miss_err == 1'b0, "R5 cleared by start", int'(miss_err), 0);
        push_fr(0, 30000, 0); push_fr(2, -30000, 0); push_fr(7, 5, 1);
        push_ch(0, 5000, 0); push_ch(2, -5000, 0); push_ch(7, -3, 1);
        exp_row[0] = 0; exp_val[0] = 32767;
        exp_row[1] = 2; exp_val[1] = -32768;
        exp_row[2] = 7; exp_val[2] = 2;
        collect("sat");
        compare(3, "sat R6");
        check(ovf == 1'b1, "R6 ovf set", int'(ovf), 1);
    endtask

    task automatic t_backpressure();
        int hr, hv;
        out_ready = 1'b0;
        do_start(1);
        check(ovf == 1'b0, "R6 ovf cleared by start", int'(ovf), 0);
        push_fr(1, 1, 0); push_fr(2, 2, 0); push_fr(3, 3, 1);
        push_ch(2, 1, 1);
        @(negedge clk);
        check(out_valid == 1'b1, "R8 stalled valid", int'(out_valid), 1);
        hr = int'(out_row); hv = int'(out_val);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(int'(out_row) == hr && int'(out_val) == hv, "R8 held", int'(out_row), hr);
        end
        exp_row[0] = 1; exp_val[0] = 1;
        exp_row[1] = 2; exp_val[1] = 3;
        exp_row[2] = 3; exp_val[2] = 3;
        collect("bp");
        compare(3, "bp R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_pass();
        t_merge();
        t_miss();
        t_sat();
        t_backpressure();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule